// File: doc/BRIEF.md
# I/O Space Read Sequencer

This block performs reads from a 64K-word I/O port space over an external memory-style bus and hands each returned word to a destination write port. A one-cycle start pulse supplies the first port address, a repeat count and a flag. The flag marks whether the destination is the accumulator half-register. A repeat count of N gives N+1 back-to-back reads, and the port address steps up by one after every read.

Each read drives the port onto the bottom 16 lines of a 22-bit address bus and pulls an active-low I/O strobe for one cycle. The word on the bottom 16 lines of the data bus is captured at the end of that cycle. The captured word is presented on the destination port in the following cycle. When the destination is the accumulator, the negative and zero flags follow each written word; otherwise they keep their old values.

Top module: `ioread_seq`

## Requirements
- R1: After a synchronous active-low reset, busy, dst_we, flag_n and flag_z are 0, io_strb_n is 1 and io_addr is 0.
- R2: During a read access, io_addr[15:0] carries the port address and io_addr[21:16] is 0; outside accesses io_addr is 0.
- R3: Only io_data[15:0] is captured; io_data[31:16] never affects dst_wdata or the flags.
- R4: io_strb_n is 0 for exactly one cycle per access, and is 1 whenever no access is in progress.
- R5: A start with repeat count N performs exactly N+1 accesses, and the first access uses start_port. Each later access uses the previous port plus 1.
- R6: Port incrementing wraps from 0xFFFF to 0x0000.
- R7: busy is 1 for exactly N+2 cycles. It rises the cycle after the accepted start and falls after the cycle that carries the final destination write.
- R8: When dst_is_acc was 1 at start, flag_n equals bit 15 of each written word, valid in the same cycle as its dst_we.
- R9: When dst_is_acc was 1 at start, flag_z is 1 if the written word is 0x0000 and 0 otherwise, valid in the same cycle as its dst_we.
- R10: When dst_is_acc was 0 at start, flag_n and flag_z keep their prior values throughout the operation.
- R11: A start pulse received while busy is 1 is ignored. The ongoing operation's ports, count and timing are unaffected.
- R12: dst_we pulses once per access, in the cycle after that access. dst_wdata then holds the word read at that access's port, and writes come in access order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin an operation |
| start_port | input | 16 | First I/O port address |
| rep_cnt | input | 16 | Repeat count N (N+1 reads) |
| dst_is_acc | input | 1 | Destination is the accumulator half-register |
| busy | output | 1 | Operation in progress |
| io_addr | output | 22 | External address bus |
| io_strb_n | output | 1 | Active-low I/O strobe |
| io_data | input | 32 | External data bus |
| dst_we | output | 1 | Destination write enable |
| dst_wdata | output | 16 | Destination write data |
| flag_n | output | 1 | Negative status flag |
| flag_z | output | 1 | Zero status flag |

## Verification
The bench sweeps start ports next to the 0xFFFF boundary and away from it, over a range of repeat counts and both destination kinds. A sequencer that failed to wrap would put a 1 onto io_addr[16]. One that miscounted repeats would show an access count or busy length off by one. The bench also puts data on the upper data lines and returns a zero word from port 0x0000. A block that captured the upper half would write wrong words, and a block that ignored the destination kind would disturb the flags on non-accumulator runs. In every run a second start is sent mid-operation, so a sequencer that restarted on it would restart its addresses or stretch busy.

// File: rtl/ioread_pkg.sv
// Shared widths and state encoding for the I/O space read sequencer.
// Assumes a 16-bit port space placed on a wider external address bus.
package ioread_pkg;
    localparam int PORT_W = 16;
    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_ACCESS = 2'd1,
        SEQ_DRAIN  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/ioread_ctrl.sv
// Sequence controller: accepts a start when idle, runs rep+1 access cycles,
// then one drain cycle for the final destination write.
// Assumes start is a single-cycle pulse; starts while busy are dropped.
module ioread_ctrl
    import ioread_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic [CNT_W-1:0] rep_cnt,
    input  logic dst_is_acc,
    output logic launch,
    output logic access,
    output logic acc_dst,
    output logic busy
);
    seq_state_t state;
    logic [CNT_W-1:0] remain;

    assign launch = (state == SEQ_IDLE) && start;
    assign access = (state == SEQ_ACCESS);
    assign busy   = (state != SEQ_IDLE);

    // Advance the state machine and the remaining-access counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            remain  <= '0;
            acc_dst <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: if (start) begin
                    state   <= SEQ_ACCESS;
                    remain  <= rep_cnt;
                    acc_dst <= dst_is_acc;
                end
                SEQ_ACCESS: begin
                    if (remain == '0) state <= SEQ_DRAIN;
                    else remain <= remain - 1'b1;
                end
                SEQ_DRAIN: state <= SEQ_IDLE;
                default:   state <= SEQ_IDLE;
            endcase
        end
    end

    // R11
    restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && state == SEQ_ACCESS && remain != '0) |=> (state == SEQ_ACCESS));
    // R7
    drain_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_DRAIN) |=> !busy);
endmodule

// File: rtl/ioread_addr.sv
// Port address generator: loads the start port on launch and post-increments
// after every access, wrapping naturally inside the 16-bit port space.
module ioread_addr
    import ioread_pkg::*;
#(
    parameter int BUS_AW = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic access,
    input  logic [PORT_W-1:0] start_port,
    output logic [BUS_AW-1:0] io_addr,
    output logic io_strb_n
);
    localparam int HI_W = BUS_AW - PORT_W;
    logic [PORT_W-1:0] port;

    // Hold the current port; step it after each access.
    always_ff @(posedge clk) begin
        if (!rst_n)      port <= '0;
        else if (launch) port <= start_port;
        else if (access) port <= port + 1'b1;
    end

    // Drive the bus only while an access is in progress.
    always_comb begin
        io_addr   = access ? {{HI_W{1'b0}}, port} : '0;
        io_strb_n = !access;
    end

    // R5 R6
    port_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (access && $past(access)) |-> (io_addr[PORT_W-1:0] == $past(io_addr[PORT_W-1:0]) + 16'd1));
    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_strb_n |-> (io_addr[BUS_AW-1:PORT_W] == '0));
endmodule

// File: rtl/ioread_capture.sv
// Capture and flag unit: latches the low data lines at the end of each access,
// raises the destination write one cycle later, and updates N/Z only for
// accumulator destinations.
module ioread_capture
    import ioread_pkg::*;
#(
    parameter int BUS_DW = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic access,
    input  logic acc_dst,
    input  logic [BUS_DW-1:0] io_data,
    output logic dst_we,
    output logic [WORD_W-1:0] dst_wdata,
    output logic flag_n,
    output logic flag_z
);
    logic [WORD_W-1:0] word;
    logic flag_upd;

    assign word     = io_data[WORD_W-1:0];
    assign flag_upd = access && acc_dst;

    // Register the read word and the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_we    <= 1'b0;
            dst_wdata <= '0;
        end else begin
            dst_we <= access;
            if (access) dst_wdata <= word;
        end
    end

    // Update status flags from the word, accumulator destination only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_n <= 1'b0;
            flag_z <= 1'b0;
        end else if (flag_upd) begin
            flag_n <= word[WORD_W-1];
            flag_z <= (word == '0);
        end
    end

    // R10
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_upd |=> $stable({flag_n, flag_z}));
    // R8 R9
    flags_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_upd |=> (flag_n == dst_wdata[WORD_W-1]) && (flag_z == (dst_wdata == '0)));
endmodule

// File: rtl/ioread_seq.sv
// Top of the I/O space read sequencer. Wires the controller, the port
// address generator and the capture/flag unit. Assumes the external device
// returns data combinationally within the strobe cycle.
module ioread_seq
    import ioread_pkg::*;
#(
    parameter int BUS_AW = 22,
    parameter int BUS_DW = 32,
    parameter int CNT_W  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic [PORT_W-1:0] start_port,
    input  logic [CNT_W-1:0] rep_cnt,
    input  logic dst_is_acc,
    output logic busy,
    output logic [BUS_AW-1:0] io_addr,
    output logic io_strb_n,
    input  logic [BUS_DW-1:0] io_data,
    output logic dst_we,
    output logic [WORD_W-1:0] dst_wdata,
    output logic flag_n,
    output logic flag_z
);
    logic launch, access, acc_dst;

    ioread_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .rep_cnt(rep_cnt),
        .dst_is_acc(dst_is_acc), .launch(launch), .access(access),
        .acc_dst(acc_dst), .busy(busy)
    );

    ioread_addr #(.BUS_AW(BUS_AW)) u_addr (
        .clk(clk), .rst_n(rst_n), .launch(launch), .access(access),
        .start_port(start_port), .io_addr(io_addr), .io_strb_n(io_strb_n)
    );

    ioread_capture #(.BUS_DW(BUS_DW)) u_cap (
        .clk(clk), .rst_n(rst_n), .access(access), .acc_dst(acc_dst),
        .io_data(io_data), .dst_we(dst_we), .dst_wdata(dst_wdata),
        .flag_n(flag_n), .flag_z(flag_z)
    );

    // R4
    strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_strb_n |-> busy);
    // R12
    write_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we |-> ($past(!io_strb_n) && busy));
endmodule

// File: tb/sim_ioread_seq.sv
module sim_ioread_seq;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [15:0] start_port = '0;
    logic [15:0] rep_cnt = '0;
    logic dst_is_acc = 1'b0;
    logic busy, io_strb_n, dst_we, flag_n, flag_z;
    logic [21:0] io_addr;
    logic [31:0] io_data;
    logic [15:0] dst_wdata;

    int vectors = 0;
    int errors = 0;
    logic exp_n = 1'b0;
    logic exp_z = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] dev_word(input logic [15:0] a);
        logic [31:0] p;
        p = {16'd0, a} * 32'h0000_9E37;
        return p[15:0];
    endfunction

    // Device model: low half is the word, upper half is noise.
    assign io_data = {~io_addr[15:0] ^ 16'h5A5A, dev_word(io_addr[15:0])};

    ioread_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_port(start_port),
        .rep_cnt(rep_cnt), .dst_is_acc(dst_is_acc), .busy(busy),
        .io_addr(io_addr), .io_strb_n(io_strb_n), .io_data(io_data),
        .dst_we(dst_we), .dst_wdata(dst_wdata), .flag_n(flag_n), .flag_z(flag_z)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [15:0] base, input int n, input logic acc);
        int accs = 0;
        int wrs = 0;
        int bcyc = 0;
        logic [15:0] a;
        @(negedge clk);
        start = 1'b1; start_port = base; rep_cnt = 16'(n); dst_is_acc = acc;
        @(negedge clk);
        start = 1'b0; start_port = base ^ 16'h0F0F; rep_cnt = 16'd7; dst_is_acc = ~acc;
        for (int i = 1; ; i++) begin
            if (!busy) begin
                start = 1'b0;
                break;
            end
            bcyc++;
            if (!io_strb_n) begin
                a = base + 16'(accs);
                check("R5 R6 port", {10'd0, io_addr}, {16'd0, a});
                check("R2 upper", {26'd0, io_addr[21:16]}, 32'd0);
                accs++;
            end
            if (dst_we) begin
                a = base + 16'(wrs);
                check("R12 R3 wdata", {16'd0, dst_wdata}, {16'd0, dev_word(a)});
                if (acc) begin
                    exp_n = dev_word(a)[15];
                    exp_z = (dev_word(a) == 16'd0);
                end
                check(acc ? "R8 R9 flags" : "R10 flags", {30'd0, flag_n, flag_z}, {30'd0, exp_n, exp_z});
                wrs++;
            end
            // R11: second start while busy
            start = (i == 2);
            if (i > n + 10) begin
                check("R7 watchdog", 32'd1, 32'd0);
                break;
            end
            @(negedge clk);
        end
        check("R5 access count", accs, n + 1);
        check("R12 write count", wrs, n + 1);
        check("R7 R11 busy cycles", bcyc, n + 2);
        check("R4 idle strobe", {31'd0, io_strb_n}, 32'd1);
        check("R10 flags at end", {30'd0, flag_n, flag_z}, {30'd0, exp_n, exp_z});
    endtask

    initial begin
        logic [15:0] bases [5];
        bases[0] = 16'h0000; bases[1] = 16'h1234; bases[2] = 16'hFFFD;
        bases[3] = 16'hFFFF; bases[4] = 16'h7FFE;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 strobe", {31'd0, io_strb_n}, 32'd1);
        check("R1 we", {31'd0, dst_we}, 32'd0);
        check("R1 addr", {10'd0, io_addr}, 32'd0);
        check("R1 flags", {30'd0, flag_n, flag_z}, 32'd0);
        for (int b = 0; b < 5; b++)
            for (int n = 0; n < 6; n++)
                for (int k = 0; k < 2; k++)
                    run_op(bases[b], n, k[0]);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule